// File: doc/BRIEF.md
# Burst Read Streamer

This block reads a range of 512-bit words out of memory through an AXI4 read master and plays them out, in ascending order, on a ready/valid stream. A single start pulse supplies a base byte address, the index of the first word and the number of words. The word at index i sits at byte address base + 64·i.

The block cuts the range into INCR bursts at run time. A burst holds at most 64 beats and never crosses a 4 KB address boundary. When the first word is not on a boundary, the first burst stops exactly at the next boundary. Later bursts carry full length, and the last one is cut to whatever remains. This holds for a start index of zero and for any nonzero index.

Returned beats land in a 64-word FIFO. A new burst goes out only when that FIFO can hold every beat already promised to it, so the read data channel is never stalled. A single-cycle done pulse marks the point where the last beat has entered the FIFO. A sticky error flag records any beat that came back with a nonzero response.

Top module: `burst_read_streamer`

## Requirements
- R1: A start pulse seen while idle captures base (its low 6 bits are treated as zero), start index and count, and busy rises on the next cycle. A start pulse seen while busy is ignored, and the run already in progress completes unchanged.
- R2: The output delivers exactly count words, those at byte addresses base + 64·(start+k) for k = 0 … count−1, in increasing k. Each request address equals the address that follows the previous request.
- R3: Every request carries size code 3'b110 (64 bytes per beat) and burst type 2'b01 (INCR), and its length field holds beats−1. A pending request keeps its address and length until it is accepted.
- R4: No request is longer than 64 beats.
- R5: No request crosses a 4 KB boundary. Each request length is min(64, beats left to the next 4 KB boundary, words remaining), so an unaligned start yields a short first burst and the following bursts are full.
- R6: The request lengths sum to the count. A count of zero issues no request, and done comes two clock edges after the start pulse is sampled.
- R7: Read data ready is held high from the first cycle after reset. A burst is issued only while FIFO free space minus beats requested and not yet returned is at least its length, so the FIFO never overflows.
- R8: While output valid is high and ready is low, output valid and data hold steady.
- R9: Done is a one-cycle pulse. It is raised one cycle after the edge that accepts the final beat of the run, and that beat carries RLAST. Busy falls with it.
- R10: A beat with nonzero RRESP sets the error flag. The flag stays set until the next accepted start pulse, which clears it.
- R11: Reset brings arvalid, output valid, busy, done and error to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| base_addr | input | 32 | Base byte address, 64-byte aligned |
| start_idx | input | 24 | Index of first word |
| word_cnt | input | 24 | Number of words |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky read-response error |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read burst byte address |
| m_arlen | output | 8 | Beats minus one |
| m_arsize | output | 3 | Beat size code |
| m_arburst | output | 2 | Burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 512 | Read data |
| m_rresp | input | 2 | Read response |
| m_rlast | input | 1 | Last beat of burst |
| o_valid | output | 1 | Output word valid |
| o_ready | input | 1 | Output word accepted |
| o_data | output | 512 | Output word |

## Verification
Every handshake is judged at the falling edge that comes before the rising edge where it completes, so request, beat and output checks line up with the edge where the design registers them. Done is due two rising edges after the final beat is shown with ready high, or two edges after the start pulse is sampled when the count is zero, and the bench compares these cycle stamps exactly. Busy and the cleared error flag are sampled at the first falling edge after the start pulse is taken. Output words are compared at the moment they are accepted, so a slow consumer shifts when a word is checked but never which value is expected.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int BEAT_BYTES = 64;
  localparam logic [2:0] AXSIZE_64B = 3'b110;
  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/brs_fifo.sv
module brs_fifo #(
  parameter int W     = 512,
  parameter int DEPTH = 64,
  parameter int OCC_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [OCC_W-1:0] mem_count,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [W-1:0]     o_data
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             pop;

  // Move a word from storage into the output register whenever it is empty or draining.
  assign pop = (mem_count != '0) && (!o_valid || o_ready);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (pop)   o_data      <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      mem_count <= '0;
      o_valid   <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)   rd_ptr <= rd_ptr + PTR_W'(1);
      mem_count <= mem_count + OCC_W'(wr_en) - OCC_W'(pop);
      if (pop)          o_valid <= 1'b1;
      else if (o_ready) o_valid <= 1'b0;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> mem_count < OCC_W'(DEPTH));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> o_valid && $stable(o_data));
endmodule

// File: rtl/brs_burst_gen.sv
module brs_burst_gen
  import brs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 24,
  parameter int CNT_W      = 24,
  parameter int MAX_BURST  = 64,
  parameter int FIFO_DEPTH = 64,
  parameter int BOUNDARY   = 4096,
  parameter int OCC_W      = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  sidx,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [OCC_W-1:0]  mem_count,
  input  logic              beat_acc,
  input  logic              beat_last,
  input  logic              arready,
  output logic              arvalid,
  output logic [ADDR_W-1:0] araddr,
  output logic [7:0]        arlen,
  output logic              busy,
  output logic              done
);
  localparam int BEAT_LG   = $clog2(BEAT_BYTES);
  localparam int BND_LG    = $clog2(BOUNDARY);
  localparam int BND_BEATS = BOUNDARY / BEAT_BYTES;
  localparam int LEN_MAX   = (MAX_BURST > BND_BEATS) ? MAX_BURST : BND_BEATS;
  localparam int LEN_W     = $clog2(LEN_MAX) + 1;
  localparam int CR_W      = OCC_W + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BEAT_BYTES - 1);

  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  remaining;
  logic [OCC_W-1:0]  outstanding;
  logic [LEN_W-1:0]  to_bnd, cap, len;
  logic [CR_W-1:0]   credit;
  logic              issue, finish;

  always_comb begin
    to_bnd = LEN_W'(BND_BEATS) - LEN_W'(cur_addr[BND_LG-1:BEAT_LG]);
    cap    = (to_bnd > LEN_W'(MAX_BURST)) ? LEN_W'(MAX_BURST) : to_bnd;
    len    = (remaining < CNT_W'(cap)) ? LEN_W'(remaining) : cap;
    credit = CR_W'(FIFO_DEPTH) - CR_W'(mem_count) - CR_W'(outstanding);
    issue  = busy && !arvalid && (remaining != '0) && (credit >= CR_W'(len));
    finish = busy && !arvalid && (remaining == '0) && (outstanding == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arvalid     <= 1'b0;
      araddr      <= '0;
      arlen       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      cur_addr    <= '0;
      remaining   <= '0;
      outstanding <= '0;
    end else begin
      done <= 1'b0;
      if (arvalid && arready) arvalid <= 1'b0;
      if (start && !busy) begin
        busy      <= 1'b1;
        cur_addr  <= (base & ALIGN_MASK) + (ADDR_W'(sidx) << BEAT_LG);
        remaining <= cnt;
      end else if (issue) begin
        arvalid   <= 1'b1;
        araddr    <= cur_addr;
        arlen     <= 8'(len - LEN_W'(1));
        cur_addr  <= cur_addr + (ADDR_W'(len) << BEAT_LG);
        remaining <= remaining - CNT_W'(len);
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      outstanding <= outstanding + (issue ? OCC_W'(len) : '0) - OCC_W'(beat_acc);
    end
  end

  assert_len_cap_R4: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> int'(arlen) < MAX_BURST);

  assert_no_cross_R5: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> int'(araddr[BND_LG-1:BEAT_LG]) + int'(arlen) < BND_BEATS);

  assert_ar_hold_R3: assert property (@(posedge clk) disable iff (rst)
    arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));

  assert_credit_R7: assert property (@(posedge clk) disable iff (rst)
    int'(outstanding) + int'(mem_count) <= FIFO_DEPTH);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_final_last_R9: assert property (@(posedge clk) disable iff (rst)
    beat_acc && outstanding == OCC_W'(1) && remaining == '0 && !arvalid |-> beat_last);
endmodule

// File: rtl/burst_read_streamer.sv
module burst_read_streamer
  import brs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 24,
  parameter int CNT_W      = 24,
  parameter int DATA_W     = 512,
  parameter int MAX_BURST  = 64,
  parameter int FIFO_DEPTH = 64,
  parameter int BOUNDARY   = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic [CNT_W-1:0]  word_cnt,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DATA_W-1:0] o_data
);
  localparam int OCC_W = $clog2(FIFO_DEPTH) + 1;

  logic [OCC_W-1:0] mem_count;
  logic             beat_acc, start_acc;

  assign beat_acc  = m_rvalid && m_rready;
  assign start_acc = start && !busy;
  assign m_arsize  = AXSIZE_64B;
  assign m_arburst = BURST_INCR;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rready <= 1'b0;
      err      <= 1'b0;
    end else begin
      m_rready <= 1'b1;
      if (start_acc)                          err <= 1'b0;
      else if (beat_acc && m_rresp != 2'b00)  err <= 1'b1;
    end
  end

  brs_burst_gen #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .MAX_BURST(MAX_BURST),
    .FIFO_DEPTH(FIFO_DEPTH), .BOUNDARY(BOUNDARY), .OCC_W(OCC_W)
  ) u_gen (
    .clk(clk), .rst(rst), .start(start), .base(base_addr), .sidx(start_idx),
    .cnt(word_cnt), .mem_count(mem_count), .beat_acc(beat_acc), .beat_last(m_rlast),
    .arready(m_arready), .arvalid(m_arvalid), .araddr(m_araddr), .arlen(m_arlen),
    .busy(busy), .done(done)
  );

  brs_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .OCC_W(OCC_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(beat_acc), .wr_data(m_rdata), .mem_count(mem_count),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data)
  );

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err && !start_acc |=> err);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> !err);

  assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> busy);
endmodule

// File: tb/burst_read_streamer_bench.sv
module burst_read_streamer_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  base_addr = '0;
  logic [23:0]  start_idx = '0;
  logic [23:0]  word_cnt = '0;
  logic         busy, done, err;
  logic         m_arvalid, m_arready = 1'b0;
  logic [31:0]  m_araddr;
  logic [7:0]   m_arlen;
  logic [2:0]   m_arsize;
  logic [1:0]   m_arburst;
  logic         m_rvalid = 1'b0, m_rready;
  logic [511:0] m_rdata = '0;
  logic [1:0]   m_rresp = '0;
  logic         m_rlast = 1'b0;
  logic         o_valid, o_ready = 1'b0;
  logic [511:0] o_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_read_streamer u_burst_read_streamer (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .start_idx(start_idx),
    .word_cnt(word_cnt), .busy(busy), .done(done), .err(err),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
    .m_arsize(m_arsize), .m_arburst(m_arburst), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  // scoreboard
  longint exp_ar_addr, exp_out_addr;
  int exp_rem, ar_beats, ar_count, out_cnt, beats_ret, total_beats;
  int done_cnt, done_cyc, last_beat_cyc, inj_beat;
  bit stall_en = 1'b0;
  longint q_addr [256];
  int q_len [256];
  int q_head = 0, q_tail = 0, q_beat = 0;
  bit prev_hold = 1'b0;
  logic [511:0] prev_data;

  function automatic logic [511:0] word_of(input logic [31:0] a);
    logic [511:0] w;
    for (int l = 0; l < 16; l++)
      w[l*32 +: 32] = a ^ (32'(l) * 32'h9E3779B9) ^ {a[15:0], a[31:16]};
    return w;
  endfunction

  function automatic int exp_len(input longint addr, input int rem);
    int tb = 64 - int'((addr >> 6) % 64);
    int l = (tb < 64) ? tb : 64;
    return (rem < l) ? rem : l;
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // Memory slave and monitor, all decisions at the falling edge.
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (prev_hold) begin
        chk("R8 valid held", longint'(o_valid), 1);
        checks++;
        if (o_data !== prev_data) begin
          fails++;
          $display("FAIL R8 data changed: got %h expected %h", o_data, prev_data);
        end
      end
      m_arready = stall_en ? ($urandom % 4 != 0) : 1'b1;
      if (m_arvalid && m_arready) begin
        chk("R3 size", longint'(m_arsize), 6);
        chk("R3 burst", longint'(m_arburst), 1);
        chk("R2 request addr", longint'(m_araddr), exp_ar_addr);
        chk("R4 len cap", longint'(int'(m_arlen) < 64), 1);
        chk("R5 no 4k cross", longint'((m_araddr % 4096) + (int'(m_arlen) + 1) * 64 <= 4096), 1);
        chk("R5 len", longint'(int'(m_arlen) + 1), longint'(exp_len(exp_ar_addr, exp_rem)));
        q_addr[q_tail] = longint'(m_araddr);
        q_len[q_tail] = int'(m_arlen) + 1;
        q_tail = (q_tail + 1) % 256;
        exp_ar_addr += 64 * (longint'(m_arlen) + 1);
        exp_rem -= int'(m_arlen) + 1;
        ar_beats += int'(m_arlen) + 1;
        ar_count++;
      end
      if (q_head != q_tail && (!stall_en || ($urandom % 4 != 0) || m_rvalid)) begin
        m_rvalid = 1'b1;
        m_rdata = word_of(32'(q_addr[q_head] + 64 * q_beat));
        m_rlast = (q_beat == q_len[q_head] - 1);
        m_rresp = (beats_ret == inj_beat) ? 2'b10 : 2'b00;
        if (!m_rready) begin
          fails++; checks++;
          $display("FAIL R7 rready low: got 0 expected 1");
        end else begin
          beats_ret++;
          if (beats_ret == total_beats) last_beat_cyc = cyc;
          if (m_rlast) begin q_head = (q_head + 1) % 256; q_beat = 0; end
          else q_beat++;
        end
      end else begin
        m_rvalid = 1'b0;
        m_rlast = 1'b0;
        m_rresp = 2'b00;
      end
      o_ready = stall_en ? ($urandom % 4 != 0) : 1'b1;
      if (o_valid && o_ready) begin
        checks++;
        if (o_data !== word_of(32'(exp_out_addr))) begin
          fails++;
          $display("FAIL R2 word %0d: got %h expected %h", out_cnt, o_data,
                   word_of(32'(exp_out_addr)));
        end
        exp_out_addr += 64;
        out_cnt++;
      end
      prev_hold = o_valid && !o_ready;
      prev_data = o_data;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  task automatic run(input longint base, input int sidx, input int cnt, input int inj,
                     input bit stall, input bit dup);
    int start_cyc, n;
    exp_ar_addr = base + 64 * longint'(sidx);
    exp_out_addr = exp_ar_addr;
    exp_rem = cnt; ar_beats = 0; ar_count = 0; out_cnt = 0; beats_ret = 0;
    total_beats = cnt; done_cnt = 0; done_cyc = -1; last_beat_cyc = -1;
    inj_beat = inj; stall_en = stall;
    @(negedge clk);
    base_addr = 32'(base); start_idx = 24'(sidx); word_cnt = 24'(cnt); start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", longint'(busy), 1);
    chk("R10 err cleared by start", longint'(err), 0);
    n = 0;
    while (done_cnt == 0 && n < 20000) begin
      @(negedge clk);
      n++;
      if (dup && n == 10) begin
        base_addr = 32'h0000_8000; start_idx = 24'd3; word_cnt = 24'd5; start = 1'b1;
      end else if (dup && n == 11) start = 1'b0;
    end
    start = 1'b0;
    if (done_cnt == 0) begin
      fails++; checks++;
      $display("FAIL R9 no done: got 0 expected 1");
    end
    n = 0;
    while (out_cnt < cnt && n < 5000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    chk("R2 output count", out_cnt, cnt);
    chk("R6 request beat sum", ar_beats, cnt);
    chk("R9 single done", done_cnt, 1);
    chk("R9 busy low after done", longint'(busy), 0);
    if (cnt == 0) begin
      chk("R6 zero count no request", ar_count, 0);
      chk("R6 zero count done timing", done_cyc - start_cyc, 2);
    end else begin
      chk("R9 done timing", done_cyc - last_beat_cyc, 2);
    end
    if (dup) chk("R1 second start ignored", ar_beats + out_cnt, 2 * cnt);
    chk("R10 error flag", longint'(err), (inj >= 0 && inj < cnt) ? 1 : 0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 arvalid reset", longint'(m_arvalid), 0);
    chk("R11 o_valid reset", longint'(o_valid), 0);
    chk("R11 busy reset", longint'(busy), 0);
    chk("R11 done reset", longint'(done), 0);
    chk("R11 err reset", longint'(err), 0);
    chk("R7 rready high", longint'(m_rready), 1);
    run(0, 0, 200, -1, 1'b0, 1'b0);        // aligned start, no stalls
    run(0, 37, 150, -1, 1'b1, 1'b0);       // unaligned: 27, 64, 59
    run(32'h1040, 5, 10, -1, 1'b1, 1'b0);  // short single burst
    run(0, 63, 3, -1, 1'b1, 1'b0);         // 1 then 2 across boundary
    run(32'h2000, 9, 0, -1, 1'b1, 1'b0);   // zero count
    run(0, 10, 100, 50, 1'b1, 1'b0);       // error beat injected
    repeat (20) @(negedge clk);
    chk("R10 err sticky while idle", longint'(err), 1);
    run(32'h4000, 1, 200, -1, 1'b1, 1'b1); // start while busy
    for (int t = 0; t < 6; t++)
      run(longint'($urandom % 4) * 4096 + longint'($urandom % 64) * 64,
          int'($urandom % 300), 1 + int'($urandom % 300), -1, 1'b1, 1'b0);
    summary();
  end
endmodule